// File: doc/BRIEF.md
# Three-Wire Byte Handshake Engine

This block moves bytes between a host processor and a device-side agent through a single shift data byte and three active-low handshake lines. Two of the lines come from the host: one marks that a transfer is in progress, the other is an acknowledge that the host toggles for each byte. The third line, a transfer request, is driven back by the device. Each time the host writes its handshake levels, the engine compares them with the levels from the previous write. Every byte step is triggered by a change in those levels; a clock tick alone never advances a transfer.

A direction input picks one of two modes. In outbound mode, each handshake change captures the host-written shift byte into a capture buffer. When the host ends the transfer, the buffer is handed on as a packet. In inbound mode, each change presents the next byte of a reply that the device agent loaded earlier. The request line then deasserts when the last reply byte has been presented. While no transfer is in progress, the request line has two jobs: it echoes the acknowledge level for synchronisation, and it asserts when reply bytes are waiting. Every step emits a one-cycle shift-event pulse.

Top module: `hs_engine`

## Requirements
- R1: After reset, `treq_n` is 1, `sr_q` is 0, `sr_irq` and `pkt_valid` are 0, and the stored previous levels of both host lines are 0 (in progress, acknowledge asserted).
- R2: `sr_irq` is high for exactly the one cycle that follows each of these events: an outbound capture, an inbound byte load, a sync echo, an end of transfer, and a reply load.
- R3: In a port write with `pb_tip_n`=0, `dir_out`=1 and a level change of `pb_ack_n` or `pb_tip_n` against the previous write, the current `sr_q` is stored in the next free capture slot.
- R4: When all `OUT_DEPTH` slots are taken, a further outbound capture write stores nothing and raises no `sr_irq`. The packet later reports exactly `OUT_DEPTH` bytes.
- R5: In a port write with `pb_tip_n`=0, `dir_out`=0, a level change and reply bytes left, `sr_q` takes the next reply byte. When that byte is the last one, `treq_n` goes to 1. When no bytes are left, the write changes neither `sr_q` nor `sr_irq`.
- R6: In a port write with `pb_tip_n`=1, where the previous write also had it at 1 and `pb_ack_n` differs from its previous level, `treq_n` takes the new `pb_ack_n` level.
- R7: In a port write with `pb_tip_n`=1 after a previous write with it at 0, `sr_irq` is raised. If at least one byte was captured, `pkt_valid` pulses for one cycle with `pkt_len` equal to the count, and capture slot i is found at `pkt_data[8i+7:8i]`. In every case, the capture count restarts at zero.
- R8: In a port write with `pb_tip_n`=1 that is not a sync echo, `treq_n` goes to 0 if unread reply bytes remain.
- R9: A `rpl_load` with `pb_we` low stores `rpl_len` bytes (byte i at `rpl_data[8i+7:8i]`), restarts the read position and raises `sr_irq`. If the last host write left `pb_tip_n` at 1 and `rpl_len` is nonzero, `treq_n` goes to 0.
- R10: A port write with `pb_tip_n`=0 and no level change against the previous write leaves `sr_q`, `treq_n` and the capture count unchanged and raises no `sr_irq`.
- R11: `sr_we` loads `sr_wdata` into `sr_q`. An inbound byte load in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pb_we | input | 1 | Host writes the handshake levels this cycle |
| pb_ack_n | input | 1 | Acknowledge level written by the host (active low) |
| pb_tip_n | input | 1 | Transfer-in-progress level written by the host (active low) |
| dir_out | input | 1 | 1: host shifts bytes out to the device; 0: device replies |
| sr_we | input | 1 | Host writes the shift data byte |
| sr_wdata | input | DW | Shift byte written by the host |
| rpl_load | input | 1 | Device agent loads a new reply |
| rpl_len | input | RCW | Reply length in bytes (at most RPL_DEPTH) |
| rpl_data | input | RPL_DEPTH*DW | Reply bytes, byte 0 in the low bits |
| treq_n | output | 1 | Transfer request to the host (active low) |
| sr_q | output | DW | Current shift data byte |
| sr_irq | output | 1 | One-cycle shift-event pulse |
| pkt_valid | output | 1 | One-cycle pulse: outbound packet complete |
| pkt_len | output | OCW | Byte count of the completed packet |
| pkt_data | output | OUT_DEPTH*DW | Capture buffer, slot 0 in the low bits |

## Verification
Outbound runs alternate toggling acknowledge with toggling in-progress. This shows that a change on either line advances the transfer and that a repeated level does not. An overlong outbound run confirms that the capture count saturates and that the excess bytes raise no event. Inbound runs that keep toggling after the last reply byte tell the end-of-data marker apart from a silent exhausted read. Idle writes are split into three kinds: acknowledge toggles, which exercise the sync echo; in-progress rising edges, which end a transfer; and replies loaded inside or outside a transfer, which show whether the request line asserts right away or only once the transfer ends.

// File: rtl/hs_pkg.sv
package hs_pkg;

   // Outcome of evaluating one host handshake write
   typedef enum logic [2:0] {
      EV_NONE    = 3'd0,
      EV_CAPTURE = 3'd1,
      EV_LOAD    = 3'd2,
      EV_SYNC    = 3'd3,
      EV_END     = 3'd4,
      EV_IDLE    = 3'd5
   } hs_ev_e;

endpackage

// File: rtl/hs_edge.sv
module hs_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic ack_n,
   input  logic tip_n,
   output logic prev_ack,
   output logic prev_tip,
   output logic chg
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_ack <= 1'b0;
         prev_tip <= 1'b0;
      end else if (we) begin
         prev_ack <= ack_n;
         prev_tip <= tip_n;
      end
   end

   assign chg = (ack_n != prev_ack) || (tip_n != prev_tip);

   // R1: previous levels follow the last write only
   p_prev_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(prev_ack) && $stable(prev_tip)));

endmodule

// File: rtl/hs_outbuf.sv
module hs_outbuf #(
   parameter  int DW    = 8,
   parameter  int DEPTH = 16,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap,
   input  logic                clr,
   input  logic [DW-1:0]       din,
   output logic [CW-1:0]       cnt,
   output logic                full,
   output logic [DEPTH*DW-1:0] data
);

   initial assert (DEPTH >= 1) else $error("hs_outbuf: DEPTH must be at least 1");

   assign full = (cnt == CW'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (cap && !full)
         cnt <= cnt + CW'(1);
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            data[i*DW +: DW] <= '0;
         else if (cap && !full && (cnt == CW'(i)))
            data[i*DW +: DW] <= din;
      end
   end

   // R4: count never passes the depth
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   // R4: a full buffer does not grow
   p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !clr) |=> full);

endmodule

// File: rtl/hs_inq.sv
module hs_inq #(
   parameter  int DW    = 8,
   parameter  int DEPTH = 16,
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int IW    = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ld,
   input  logic [CW-1:0]       ld_len,
   input  logic [DEPTH*DW-1:0] ld_data,
   input  logic                adv,
   output logic [DW-1:0]       cur,
   output logic                pending,
   output logic                last
);

   initial assert (DEPTH >= 2) else $error("hs_inq: DEPTH must be at least 2");

   logic [DW-1:0] mem [DEPTH];
   logic [CW-1:0] idx;
   logic [CW-1:0] len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
         len <= '0;
      end else if (ld) begin
         idx <= '0;
         len <= ld_len;
      end else if (adv && pending) begin
         idx <= idx + CW'(1);
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[i] <= '0;
         else if (ld)
            mem[i] <= ld_data[i*DW +: DW];
      end
   end

   assign pending = (idx < len);
   assign last    = ((idx + CW'(1)) == len);
   assign cur     = mem[idx[IW-1:0]];

   // R9: a length beyond the depth is illegal
   p_len_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ld |-> (ld_len <= CW'(DEPTH)));

   // R5: read position never passes the length
   p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= len);

endmodule

// File: rtl/hs_engine.sv
module hs_engine
   import hs_pkg::*;
#(
   parameter  int DW        = 8,
   parameter  int OUT_DEPTH = 16,
   parameter  int RPL_DEPTH = 16,
   localparam int OCW       = $clog2(OUT_DEPTH + 1),
   localparam int RCW       = $clog2(RPL_DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pb_we,
   input  logic                    pb_ack_n,
   input  logic                    pb_tip_n,
   input  logic                    dir_out,
   input  logic                    sr_we,
   input  logic [DW-1:0]           sr_wdata,
   input  logic                    rpl_load,
   input  logic [RCW-1:0]          rpl_len,
   input  logic [RPL_DEPTH*DW-1:0] rpl_data,
   output logic                    treq_n,
   output logic [DW-1:0]           sr_q,
   output logic                    sr_irq,
   output logic                    pkt_valid,
   output logic [OCW-1:0]          pkt_len,
   output logic [OUT_DEPTH*DW-1:0] pkt_data
);

   initial assert (DW >= 1) else $error("hs_engine: DW must be at least 1");

   logic           prev_ack, prev_tip, chg;
   logic [OCW-1:0] out_cnt;
   logic           out_full;
   logic [DW-1:0]  in_cur;
   logic           in_pend, in_last;
   logic           rpl_ok;
   hs_ev_e         ev;

   hs_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (pb_we),
      .ack_n    (pb_ack_n),
      .tip_n    (pb_tip_n),
      .prev_ack (prev_ack),
      .prev_tip (prev_tip),
      .chg      (chg)
   );

   hs_outbuf #(.DW(DW), .DEPTH(OUT_DEPTH)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (ev == EV_CAPTURE),
      .clr   (ev == EV_END),
      .din   (sr_q),
      .cnt   (out_cnt),
      .full  (out_full),
      .data  (pkt_data)
   );

   assign rpl_ok = rpl_load && !pb_we;

   hs_inq #(.DW(DW), .DEPTH(RPL_DEPTH)) u_in (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (rpl_ok),
      .ld_len  (rpl_len),
      .ld_data (rpl_data),
      .adv     (ev == EV_LOAD),
      .cur     (in_cur),
      .pending (in_pend),
      .last    (in_last)
   );

   // Classify the host write against the previous levels
   always_comb begin
      ev = EV_NONE;
      if (pb_we) begin
         if (!pb_tip_n) begin
            if (dir_out) begin
               if (chg && !out_full) ev = EV_CAPTURE;
            end else if (chg && in_pend) begin
               ev = EV_LOAD;
            end
         end else if (prev_tip && (pb_ack_n != prev_ack)) begin
            ev = EV_SYNC;
         end else if (!prev_tip) begin
            ev = EV_END;
         end else begin
            ev = EV_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         treq_n    <= 1'b1;
         sr_q      <= '0;
         sr_irq    <= 1'b0;
         pkt_valid <= 1'b0;
         pkt_len   <= '0;
      end else begin
         sr_irq    <= (ev == EV_CAPTURE) || (ev == EV_LOAD) || (ev == EV_SYNC) ||
                      (ev == EV_END) || rpl_ok;
         pkt_valid <= (ev == EV_END) && (out_cnt != '0);
         if (ev == EV_END) pkt_len <= out_cnt;

         if (ev == EV_LOAD)
            sr_q <= in_cur;
         else if (sr_we)
            sr_q <= sr_wdata;

         case (ev)
            EV_LOAD: if (in_last) treq_n <= 1'b1;
            EV_SYNC: treq_n <= pb_ack_n;
            EV_END, EV_IDLE: if (in_pend) treq_n <= 1'b0;
            default: if (rpl_ok && prev_tip && (rpl_len != '0)) treq_n <= 1'b0;
         endcase
      end
   end

   // R6: idle acknowledge change is echoed on the request line
   p_sync_echo_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pb_we && pb_tip_n && prev_tip && (pb_ack_n != prev_ack)) |=> (treq_n == $past(pb_ack_n)));

   // R5: last reply byte deasserts the request line
   p_end_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pb_we && !pb_tip_n && !dir_out && chg && in_pend && in_last) |=> treq_n);

   // R4: a capture into a full buffer raises no event
   p_drop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pb_we && !pb_tip_n && dir_out && out_full && !rpl_load) |=> !sr_irq);

   // R7: a packet never reports zero bytes
   p_pkt_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> (pkt_len != '0));

   // R7: end of transfer always raises the event
   p_end_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pb_we && pb_tip_n && !prev_tip) |=> sr_irq);

   // R10: write with no level change during a transfer is inert
   p_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pb_we && !pb_tip_n && !chg && !sr_we) |=> ($stable(sr_q) && $stable(treq_n) && !sr_irq));

endmodule

// File: tb/hs_engine_test.sv
module hs_engine_test;

   localparam int DW  = 8;
   localparam int OD  = 16;
   localparam int RD  = 16;
   localparam int OCW = $clog2(OD + 1);
   localparam int RCW = $clog2(RD + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pb_we = 1'b0, pb_ack_n = 1'b0, pb_tip_n = 1'b0, dir_out = 1'b0;
   logic sr_we = 1'b0;
   logic [DW-1:0] sr_wdata = '0;
   logic rpl_load = 1'b0;
   logic [RCW-1:0] rpl_len = '0;
   logic [RD*DW-1:0] rpl_data = '0;
   logic treq_n, sr_irq, pkt_valid;
   logic [DW-1:0] sr_q;
   logic [OCW-1:0] pkt_len;
   logic [OD*DW-1:0] pkt_data;

   always #5ns clk = ~clk;

   hs_engine #(.DW(DW), .OUT_DEPTH(OD), .RPL_DEPTH(RD)) uut (
      .clk(clk), .rst_n(rst_n), .pb_we(pb_we), .pb_ack_n(pb_ack_n), .pb_tip_n(pb_tip_n),
      .dir_out(dir_out), .sr_we(sr_we), .sr_wdata(sr_wdata), .rpl_load(rpl_load),
      .rpl_len(rpl_len), .rpl_data(rpl_data), .treq_n(treq_n), .sr_q(sr_q),
      .sr_irq(sr_irq), .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_data(pkt_data)
   );

   int checks = 0;
   int errors = 0;

   // reference model state
   bit   m_pack, m_ptip, m_treq, m_irq, m_pv;
   byte  m_sr;
   int   m_plen;
   byte  oq[$];
   byte  pq[$];
   byte  rmem[RD];
   byte  rnext[RD];
   int   ridx, rlen;

   task automatic check(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic compare_all();
      check("R5 treq_n", longint'(treq_n), longint'(m_treq));
      check("R2 sr_irq", longint'(sr_irq), longint'(m_irq));
      check("R11 sr_q", longint'(sr_q), longint'(m_sr) & 8'hff);
      check("R7 pkt_valid", longint'(pkt_valid), longint'(m_pv));
      if (m_pv) begin
         check("R7 pkt_len", longint'(pkt_len), longint'(m_plen));
         foreach (pq[i])
            check("R7 pkt_data", longint'(pkt_data[i*8 +: 8]), longint'(pq[i]) & 8'hff);
      end
   endtask

   // one clock step: drive at negedge, advance model, compare at next negedge
   task automatic step(bit we, bit ack, bit tip, bit srw, byte srd, bit ld, int len);
      bit chg, loaded;
      byte nsr;
      pb_we = we; pb_ack_n = ack; pb_tip_n = tip;
      sr_we = srw; sr_wdata = srd; rpl_load = ld; rpl_len = RCW'(len);
      for (int i = 0; i < RD; i++) rpl_data[i*8 +: 8] = rnext[i];
      m_irq = 0; m_pv = 0; loaded = 0; nsr = 0;
      chg = (ack != m_pack) || (tip != m_ptip);
      if (we) begin
         if (!tip) begin
            if (dir_out) begin
               if (chg && oq.size() < OD) begin oq.push_back(m_sr); m_irq = 1; end
            end else if (chg && ridx < rlen) begin
               nsr = rmem[ridx]; ridx++; loaded = 1; m_irq = 1;
               if (ridx == rlen) m_treq = 1;
            end
         end else if (m_ptip && ack != m_pack) begin
            m_treq = ack; m_irq = 1;
         end else begin
            if (!m_ptip) begin
               m_irq = 1;
               if (oq.size() > 0) begin m_pv = 1; m_plen = oq.size(); pq = oq; end
               oq.delete();
            end
            if (ridx < rlen) m_treq = 0;
         end
         m_pack = ack; m_ptip = tip;
      end else if (ld) begin
         rlen = len; ridx = 0;
         for (int i = 0; i < RD; i++) rmem[i] = rnext[i];
         if (m_ptip && len > 0) m_treq = 0;
         m_irq = 1;
      end
      if (loaded) m_sr = nsr;
      else if (srw) m_sr = srd;
      @(negedge clk);
      compare_all();
      pb_we = 0; sr_we = 0; rpl_load = 0;
   endtask

   task automatic pbw(bit ack, bit tip); step(1, ack, tip, 0, 0, 0, 0); endtask
   task automatic srw(byte d);           step(0, m_pack, m_ptip, 1, d, 0, 0); endtask
   task automatic idle();                step(0, m_pack, m_ptip, 0, 0, 0, 0); endtask
   task automatic load(int n);           step(0, m_pack, m_ptip, 0, 0, 1, n); endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_pack = 0; m_ptip = 0; m_treq = 1; m_irq = 0; m_pv = 0; m_sr = 0;
      ridx = 0; rlen = 0; m_plen = 0;
      for (int i = 0; i < RD; i++) begin rmem[i] = 0; rnext[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 treq_n", longint'(treq_n), 1);
      check("R1 sr_q", longint'(sr_q), 0);
      check("R1 sr_irq", longint'(sr_irq), 0);
      check("R1 pkt_valid", longint'(pkt_valid), 0);

      // R7 end of transfer with nothing captured: event only
      pbw(1, 1);
      idle();

      // R3 outbound: ack toggles and a tip change both capture
      dir_out = 1;
      srw(8'h11); pbw(1, 0);        // tip falls -> capture 11
      srw(8'h22); pbw(0, 0);        // ack change -> capture 22
      pbw(0, 0);                    // R10 no change
      check("R10 quiet", longint'(sr_irq), 0);
      srw(8'h33); pbw(1, 0);        // capture 33
      pbw(1, 1);                    // R7 end with 3 bytes
      check("R7 len3", longint'(pkt_len), 3);
      idle();

      // R4 overflow: 18 toggles, only OD captured
      for (int k = 0; k < 18; k++) begin
         srw(byte'(8'hA0 + k));
         pbw(bit'(k % 2), 0);
      end
      pbw(0, 1);
      check("R4 len saturates", longint'(pkt_len), OD);
      idle();

      // R9 reply load while idle asserts request
      dir_out = 0;
      rnext[0] = 8'h5A; rnext[1] = 8'hC3; rnext[2] = 8'h7E;
      load(3);
      check("R9 treq low", longint'(treq_n), 0);
      // R5 inbound bytes
      pbw(0, 0);                    // tip falls -> byte0
      check("R5 byte0", longint'(sr_q), 8'h5A);
      pbw(1, 0);
      pbw(0, 0);                    // last byte -> treq high
      check("R5 end mark", longint'(treq_n), 1);
      pbw(1, 0);                    // exhausted: nothing
      check("R5 exhausted", longint'(sr_irq), 0);
      srw(8'h44); pbw(0, 0);        // R11 host write kept
      pbw(0, 1);                    // end, no packet
      idle();

      // R6 sync echo
      pbw(1, 1);
      check("R6 echo high", longint'(treq_n), 1);
      pbw(0, 1);
      check("R6 echo low", longint'(treq_n), 0);
      pbw(1, 1);
      idle();

      // R9/R8 reply loaded inside a transfer: request waits for the end
      pbw(1, 0);
      rnext[0] = 8'h99;
      load(1);
      check("R9 in-transfer no treq", longint'(treq_n), 1);
      pbw(1, 1);
      check("R8 pending treq", longint'(treq_n), 0);
      pbw(1, 1);                    // idle write, still pending
      pbw(1, 0);                    // read the byte
      check("R5 single byte", longint'(sr_q), 8'h99);
      pbw(1, 1);

      // R9 zero-length reply: event, no request
      load(0);
      check("R9 zero len treq", longint'(treq_n), 1);
      idle();

      // R11 inbound load beats host write in same cycle
      rnext[0] = 8'h0F; rnext[1] = 8'hF0;
      load(2);
      step(1, 1, 0, 1, 8'hEE, 0, 0);
      check("R11 load wins", longint'(sr_q), 8'h0F);
      pbw(0, 0);
      pbw(0, 1);
      idle();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule